// File: doc/BRIEF.md
# Branch and Loop Condition Evaluator

This block decides whether a conditional transfer of control happens. A control unit presents, on one cycle, a request strobe with a 4-bit condition code, the five status flags (carry, zero, sign, overflow, parity), a loop-mode selector and the current value of the count register. One clock later the block shows a registered `taken` bit. In loop mode it also shows the decremented count, which the control unit writes back to its register file.

There are two kinds of request. A jump request tests the flags against the condition code. The codes come in pairs, and each odd code is the negation of the even code before it. Three of the pairs test flag combinations: unsigned ordering (carry and zero), signed ordering (sign, overflow and zero), and the sign/overflow mismatch alone. A loop request ignores the condition code. It decrements the count and takes the branch when the new count is nonzero. Two loop variants also require the zero flag to be set, or to be clear. Target address computation and instruction-queue handling are done elsewhere.

Top module: `branch_loop_eval`

## Requirements
- R1: While reset (`rst_n` low) is asserted and in the first cycle after it, `taken` is 0 and `count_out` is 0000h.
- R2: For a jump request (`op_valid`=1, `loop_mode`=0), the single-flag codes give `taken` one cycle later as follows: code 0 when OF=1, 1 when OF=0, 4 when ZF=1, 5 when ZF=0, 8 when SF=1, 9 when SF=0, 10 when PF=1, 11 when PF=0.
- R3: Unsigned ordering codes: 2 (below) is taken when CF=1, 3 (above-or-equal) when CF=0, 6 (below-or-equal) when CF=1 or ZF=1, and 7 (above) when CF=0 and ZF=0.
- R4: Signed ordering codes: 12 (less) is taken when SF differs from OF, 13 (greater-or-equal) when SF equals OF, 14 (less-or-equal) when ZF=1 or SF differs from OF, and 15 (greater) when ZF=0 and SF equals OF.
- R5: `taken` is a register. It reflects the request of the previous cycle, and it is 0 in the cycle after any cycle with `op_valid`=0, whatever the other inputs are.
- R6: `loop_mode` encodes 0 = jump, 1 = plain loop, 2 = loop while ZF=1, 3 = loop while ZF=0. For a plain loop request, `count_out` becomes `count_in`−1 one cycle later, and `taken` is 1 exactly when that new count is nonzero. The condition code and the CF, SF, OF and PF flags have no effect on a loop request.
- R7: Mode 2 takes the branch only when the new count is nonzero and ZF=1. Mode 3 takes it only when the new count is nonzero and ZF=0. Both modes decrement the count whether or not the branch is taken.
- R8: A loop request with `count_in`=0000h yields `count_out`=FFFFh and is taken, unless its zero-flag qualifier fails.
- R9: `count_out` changes only in the cycle after a loop request (`op_valid`=1 with `loop_mode`≠0). Jump requests and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Evaluation request for this cycle |
| cond_code | input | 4 | Condition code for jump requests |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| loop_mode | input | 2 | 0 jump, 1 plain loop, 2 loop while ZF=1, 3 loop while ZF=0 |
| count_in | input | 16 | Current count register value |
| taken | output | 1 | Registered branch decision |
| count_out | output | 16 | Registered decremented count, held between loop requests |

## Verification
The hardest case to reach from the ports is a loop request whose count qualifier and zero-flag qualifier disagree. One such case is a count of 1, which reaches zero even though ZF would allow the branch. Another is a count of 0, which wraps to FFFFh even though ZF would forbid the branch. The stimulus sweeps each loop mode against both ZF values over counts 0, 1, 2, 8000h and FFFFh. It changes the condition code and the other flags between requests, so any leakage of jump logic into loop decisions shows up. Idle cycles and jump requests with unrelated `count_in` values are placed between loop requests, so that any unintended write to the count register is caught.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

  localparam int COND_W = 4;

  typedef enum logic [1:0] {
    LM_JUMP     = 2'd0,
    LM_PLAIN    = 2'd1,
    LM_WHILE_Z  = 2'd2,
    LM_WHILE_NZ = 2'd3
  } loop_mode_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } flags_t;

  // Per-code decision, written out code by code.
  function automatic logic cond_hit(input logic [COND_W-1:0] code, input flags_t f);
    logic r;
    case (code)
      4'h0: r = f.of;
      4'h1: r = ~f.of;
      4'h2: r = f.cf;
      4'h3: r = ~f.cf;
      4'h4: r = f.zf;
      4'h5: r = ~f.zf;
      4'h6: r = f.cf | f.zf;
      4'h7: r = ~f.cf & ~f.zf;
      4'h8: r = f.sf;
      4'h9: r = ~f.sf;
      4'hA: r = f.pf;
      4'hB: r = ~f.pf;
      4'hC: r = f.sf ^ f.of;
      4'hD: r = ~(f.sf ^ f.of);
      4'hE: r = f.zf | (f.sf ^ f.of);
      default: r = ~f.zf & ~(f.sf ^ f.of);
    endcase
    return r;
  endfunction

  // Zero-flag qualifier for the loop variants.
  function automatic logic loop_qual(input loop_mode_e m, input logic zf);
    logic r;
    case (m)
      LM_WHILE_Z:  r = zf;
      LM_WHILE_NZ: r = ~zf;
      default:     r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bl_cond_decode.sv
module bl_cond_decode
  import brcond_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  flags_t            flags,
  output logic              hit
);
  always_comb hit = cond_hit(code, flags);
endmodule

// File: rtl/bl_loop_step.sv
module bl_loop_step
  import brcond_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_cur,
  input  loop_mode_e       mode,
  input  logic             zf,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             cnt_nz,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    cnt_dec = cnt_cur - ONE;
    cnt_nz  = |cnt_dec;
    hit     = cnt_nz & loop_qual(mode, zf);
  end
endmodule

// File: rtl/branch_loop_eval.sv
module branch_loop_eval
  import brcond_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        cond_code,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_sf,
  input  logic              flag_of,
  input  logic              flag_pf,
  input  logic [1:0]        loop_mode,
  input  logic [CNT_W-1:0]  count_in,
  output logic              taken,
  output logic [CNT_W-1:0]  count_out
);
  flags_t           flags_w;
  loop_mode_e       mode_w;
  logic             jump_hit;
  logic             loop_hit;
  logic             cnt_nz;
  logic [CNT_W-1:0] cnt_next;
  logic             is_loop;
  logic             cnt_we;
  logic             take_next;

  always_comb begin
    flags_w = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of, pf: flag_pf};
    mode_w  = loop_mode_e'(loop_mode);
  end

  bl_cond_decode u_dec (
    .code  (cond_code),
    .flags (flags_w),
    .hit   (jump_hit)
  );

  bl_loop_step #(.CNT_W(CNT_W)) u_step (
    .cnt_cur (count_in),
    .mode    (mode_w),
    .zf      (flag_zf),
    .cnt_dec (cnt_next),
    .cnt_nz  (cnt_nz),
    .hit     (loop_hit)
  );

  always_comb begin
    is_loop   = (mode_w != LM_JUMP);
    cnt_we    = op_valid & is_loop;
    take_next = op_valid & (is_loop ? loop_hit : jump_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken     <= 1'b0;
      count_out <= '0;
    end else begin
      taken <= take_next;
      if (cnt_we) count_out <= cnt_next;
    end
  end
endmodule

// File: rtl/branch_loop_eval_chk.sv
module branch_loop_eval_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [3:0]       cond_code,
  input logic             flag_zf,
  input logic             flag_sf,
  input logic             flag_of,
  input logic [1:0]       loop_mode,
  input logic [CNT_W-1:0] count_in,
  input logic             cnt_we,
  input logic             cnt_nz,
  input logic             taken,
  input logic [CNT_W-1:0] count_out
);
  // R5: an idle cycle clears the decision
  p_idle_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !taken);

  // R9: count register holds without a loop request
  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> $stable(count_out));

  // R6: a loop request stores the decremented count
  p_loop_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && loop_mode != 2'd0) |=> (count_out == $past(count_in) - 1'b1));

  // R6: a loop is never taken onto a zero count
  p_loop_nz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && loop_mode != 2'd0 && !cnt_nz) |=> !taken);

  // R7: the zero-flag qualifiers veto the branch
  p_while_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && loop_mode == 2'd2 && !flag_zf) |=> !taken);
  p_while_nz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && loop_mode == 2'd3 && flag_zf) |=> !taken);

  // R4: signed greater needs sign equal to overflow
  p_greater_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && loop_mode == 2'd0 && cond_code == 4'hF && (flag_sf != flag_of)) |=> !taken);
endmodule

bind branch_loop_eval branch_loop_eval_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .cond_code (cond_code),
  .flag_zf   (flag_zf),
  .flag_sf   (flag_sf),
  .flag_of   (flag_of),
  .loop_mode (loop_mode),
  .count_in  (count_in),
  .cnt_we    (cnt_we),
  .cnt_nz    (cnt_nz),
  .taken     (taken),
  .count_out (count_out)
);

// File: tb/branch_loop_eval_test.sv
`timescale 1ns/1ps
module branch_loop_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  cond_code = '0;
  logic        flag_cf = 1'b0, flag_zf = 1'b0, flag_sf = 1'b0, flag_of = 1'b0, flag_pf = 1'b0;
  logic [1:0]  loop_mode = '0;
  logic [15:0] count_in = '0;
  logic        taken;
  logic [15:0] count_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] cnt_model = 16'h0000;

  always #2.5 clk = ~clk;

  branch_loop_eval uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cond_code(cond_code),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of),
    .flag_pf(flag_pf), .loop_mode(loop_mode), .count_in(count_in),
    .taken(taken), .count_out(count_out)
  );

  // Pairwise model: even code tests a base term, odd code its negation.
  function automatic logic exp_jump(input logic [3:0] c, input logic [4:0] f);
    logic cf, zf, sf, of, pf, base;
    {cf, zf, sf, of, pf} = f;
    case (c[3:1])
      3'd0: base = of;
      3'd1: base = cf;
      3'd2: base = zf;
      3'd3: base = cf || zf;
      3'd4: base = sf;
      3'd5: base = pf;
      3'd6: base = (sf != of);
      default: base = zf || (sf != of);
    endcase
    return c[0] ? !base : base;
  endfunction

  task automatic chk1(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s taken act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s count act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_jump(input logic [3:0] c, input logic [4:0] f);
    string req;
    @(negedge clk);
    op_valid = 1'b1; loop_mode = 2'd0; cond_code = c;
    {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = f;
    count_in = 16'h5A00 ^ {12'h0, c};
    @(negedge clk);
    req = (c == 4'h2 || c == 4'h3 || c == 4'h6 || c == 4'h7) ? "R3" :
          (c >= 4'hC) ? "R4" : "R2";
    chk1(req, taken, exp_jump(c, f));
    chk16("R9", count_out, cnt_model);
  endtask

  task automatic do_loop(input logic [1:0] m, input logic zf, input logic [15:0] cnt,
                         input logic [3:0] junk);
    logic [15:0] nc;
    logic        exp;
    @(negedge clk);
    op_valid = 1'b1; loop_mode = m; cond_code = junk; count_in = cnt;
    flag_zf = zf; flag_cf = junk[0]; flag_sf = junk[1]; flag_of = junk[2]; flag_pf = junk[3];
    nc  = cnt + 16'hFFFF;
    exp = (nc != 16'h0000) && (m == 2'd1 || (m == 2'd2 && zf) || (m == 2'd3 && !zf));
    cnt_model = nc;
    @(negedge clk);
    if (cnt == 16'h0000) begin
      chk16("R8", count_out, 16'hFFFF);
      chk1("R8", taken, exp);
    end else if (m == 2'd1) begin
      chk16("R6", count_out, nc);
      chk1("R6", taken, exp);
    end else begin
      chk16("R7", count_out, nc);
      chk1("R7", taken, exp);
    end
  endtask

  task automatic do_idle(input logic [3:0] c);
    @(negedge clk);
    op_valid = 1'b0; loop_mode = 2'd1; cond_code = c; count_in = 16'h0003;
    {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = 5'b11111;
    @(negedge clk);
    chk1("R5", taken, 1'b0);
    chk16("R9", count_out, cnt_model);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] counts [5];
    counts[0] = 16'h0000; counts[1] = 16'h0001; counts[2] = 16'h0002;
    counts[3] = 16'h8000; counts[4] = 16'hFFFF;

    repeat (3) @(negedge clk);
    chk1("R1", taken, 1'b0);
    chk16("R1", count_out, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R1", taken, 1'b0);
    chk16("R1", count_out, 16'h0000);

    // Exhaustive jump sweep: all codes against all flag patterns.
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        do_jump(c[3:0], f[4:0]);

    // Loop sweep with jumps and idle cycles between requests.
    for (int m = 1; m < 4; m++)
      for (int z = 0; z < 2; z++)
        for (int k = 0; k < 5; k++) begin
          do_loop(m[1:0], z[0], counts[k], 4'(m * 5 + k * 3 + z));
          do_jump(4'(k + 2 * m), 5'(k * 7 + z));
          do_idle(4'(k));
        end

    // Back-to-back requests: decision follows only the previous cycle (R5).
    do_loop(2'd1, 1'b0, 16'h0010, 4'hF);
    do_jump(4'h4, 5'b01000);
    do_loop(2'd3, 1'b1, 16'h0005, 4'h0);
    do_idle(4'h7);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule